// File: doc/BRIEF.md
# Guarded Interrupt Vector Base Selector

This block holds the control register that decides where the interrupt vector table lives: either at word address zero of program memory or at the first word of the boot section. The boot section start is taken from a small table selected by a 2-bit boot-size code. The select bit is protected: it only changes through a two-write unlock sequence. First an arming write opens a short window. Then, inside that window, a committing write supplies the new select value.

While the unlock window is open, and after a commit until the next instruction retires, the block raises an interrupt-block output. The processor core uses this output to hold off interrupt acceptance. The block never touches any global interrupt-enable state; the only effect of the blocking is on its own output. On top of the timed blocking, two lock flags forbid interrupts in the code region that does not hold the vector table. Which region is executing is reported by an input from the core.

The core, the non-volatile configuration storage and the program memory stay outside this block. A write strobe with 8-bit data and a readback bus give the core access to the register.

Top module: `vector_base_ctrl`

## Requirements
- R1: `vec_base` is 0 while the select bit reads 0. While the select bit reads 1, it equals MEM_WORDS - (BOOT_MIN << (3 - boot_size)); with the defaults, codes 0, 1, 2 and 3 give 0x7000, 0x7800, 0x7C00 and 0x7E00. The output follows `boot_size` combinationally.
- R2: Readback bit 1 is the select bit and bit 0 is the change-enable bit. Bits 7:2 are plain storage. All bits are 0 after reset, and every write loads `wr_data[7:2]` into bits 7:2, visible in the cycle after the write.
- R3: The select bit changes only on a write with `wr_data[0]`=0 made while change-enable reads 1. Any other write, including an arming write with `wr_data[0]`=1, leaves the select bit unchanged.
- R4: A write with `wr_data[0]`=1 makes change-enable read 1 from the next cycle for exactly WINDOW (4) cycles, after which it reads 0. A committing write clears it in the next cycle. A further arming write while it reads 1 restarts the full count.
- R5: A commit loads `wr_data[1]` into the select bit, and the select bit and `vec_base` change in the cycle after the write. A commit on the fourth cycle of the window is accepted; a write one cycle later is ignored.
- R6: `irq_block` is 1 in every cycle in which change-enable reads 1.
- R7: After a commit, `irq_block` stays 1 until `retire` is sampled high at a clock edge after the commit edge. It is then 0 from the following cycle, unless a lock applies. A `retire` coinciding with the commit does not count. Without a commit, the timed block ends together with change-enable.
- R8: With the select bit at 1, `lock_app`=1 and `pc_in_boot`=0, `irq_block` is 1 combinationally.
- R9: With the select bit at 0, `lock_boot`=1 and `pc_in_boot`=1, `irq_block` is 1 combinationally. No other combination of lock flags, select bit and region raises it once the timed blocking has ended.
- R10: Arming, commit and window expiry never alter readback bits 7:2 beyond the value the triggering write itself loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| retire | input | 1 | One instruction retired this cycle |
| boot_size | input | 2 | Boot section size code |
| lock_app | input | 1 | Forbid interrupts outside the boot region when vectors are in boot |
| lock_boot | input | 1 | Forbid interrupts inside the boot region when vectors are in the application area |
| pc_in_boot | input | 1 | Program counter lies in the boot region |
| vec_base | output | 16 | Interrupt vector table word address |
| irq_block | output | 1 | Hold off interrupt acceptance |
| rdata | output | 8 | Register readback |

## Verification
Register effects of a write (stored bits, select, change-enable) are due one clock after the write edge. The bench drives each write across one edge and reads back at the following falling edge. Window length is counted in those same falling edges, so a commit placed after three idle cycles lands exactly on the last accepted edge, and one more idle cycle makes it late. `vec_base` and the lock part of `irq_block` are combinational, so the sweep changes `boot_size`, lock flags and region between edges and checks after a short settle delay. The release of the post-commit block is checked at the falling edge after the edge where `retire` was high.

// File: rtl/vector_base_pkg.sv
package vector_base_pkg;
   localparam int REG_W    = 8;
   localparam int CE_BIT   = 0;
   localparam int SEL_BIT  = 1;
   localparam int GEN_LO   = 2;

   typedef struct packed {
      logic [REG_W-1:GEN_LO] gen;
      logic                  sel;
      logic                  ce;
   } ctl_reg_t;
endpackage

// File: rtl/vbc_unlock_timer.sv
module vbc_unlock_timer #(
   parameter int WINDOW = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   input  logic commit_try,
   output logic win_open,
   output logic commit
);
   localparam int CW = $clog2(WINDOW + 1);
   localparam logic [CW-1:0] WIN_C = CW'(WINDOW);

   logic [CW-1:0] cnt_q;

   assign win_open = (cnt_q != '0);
   assign commit   = commit_try & win_open;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (arm) begin
         cnt_q <= WIN_C;
      end else if (commit) begin
         cnt_q <= '0;
      end else if (win_open) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end
endmodule

// File: rtl/vbc_retire_hold.sv
module vbc_retire_hold (
   input  logic clk,
   input  logic rst_n,
   input  logic commit,
   input  logic retire,
   output logic hold
);
   logic pend_q;

   assign hold = pend_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
      end else if (commit) begin
         pend_q <= 1'b1;
      end else if (retire) begin
         pend_q <= 1'b0;
      end
   end
endmodule

// File: rtl/vbc_boot_table.sv
module vbc_boot_table #(
   parameter int ADDR_W   = 16,
   parameter int SIZE_W   = 2,
   parameter int MEM_WORDS = 32768,
   parameter int BOOT_MIN = 512
) (
   input  logic [SIZE_W-1:0] code,
   output logic [ADDR_W-1:0] start
);
   localparam int N_CODES = 2 ** SIZE_W;

   logic [ADDR_W-1:0] starts [N_CODES];

   for (genvar g = 0; g < N_CODES; g++) begin : g_entry
      localparam int SZ = BOOT_MIN << (N_CODES - 1 - g);
      assign starts[g] = ADDR_W'(MEM_WORDS - SZ);
   end

   assign start = starts[code];
endmodule

// File: rtl/vbc_region_mask.sv
module vbc_region_mask (
   input  logic sel,
   input  logic lock_app,
   input  logic lock_boot,
   input  logic pc_in_boot,
   output logic lock_block
);
   logic app_deny;
   logic boot_deny;

   assign app_deny   = sel & lock_app & ~pc_in_boot;
   assign boot_deny  = ~sel & lock_boot & pc_in_boot;
   assign lock_block = app_deny | boot_deny;
endmodule

// File: rtl/vector_base_ctrl.sv
module vector_base_ctrl
   import vector_base_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int SIZE_W    = 2,
   parameter int MEM_WORDS = 32768,
   parameter int BOOT_MIN  = 512,
   parameter int WINDOW    = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [7:0]        wr_data,
   input  logic              retire,
   input  logic [SIZE_W-1:0] boot_size,
   input  logic              lock_app,
   input  logic              lock_boot,
   input  logic              pc_in_boot,
   output logic [ADDR_W-1:0] vec_base,
   output logic              irq_block,
   output logic [7:0]        rdata
);
   localparam int N_CODES = 2 ** SIZE_W;
   localparam int GEN_W   = REG_W - GEN_LO;

   if (REG_W != 8) begin : g_bad_regw
      $error("register width must be 8");
   end
   if (WINDOW < 1 || WINDOW > 15) begin : g_bad_window
      $error("WINDOW out of range");
   end
   if ((MEM_WORDS & (MEM_WORDS - 1)) != 0) begin : g_bad_mem
      $error("MEM_WORDS must be a power of two");
   end
   if ((BOOT_MIN << (N_CODES - 1)) > MEM_WORDS) begin : g_bad_boot
      $error("largest boot section exceeds memory");
   end
   if (MEM_WORDS > (2 ** ADDR_W)) begin : g_bad_addr
      $error("ADDR_W too small for MEM_WORDS");
   end

   logic       arm;
   logic       commit_try;
   logic       win_open;
   logic       commit;
   logic       hold;
   logic       lock_block;
   logic       sel_q;
   logic [GEN_W-1:0] gen_q;
   logic [ADDR_W-1:0] boot_start;
   ctl_reg_t   view;

   assign arm        = wr_en & wr_data[CE_BIT];
   assign commit_try = wr_en & ~wr_data[CE_BIT];

   vbc_unlock_timer #(.WINDOW(WINDOW)) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .arm        (arm),
      .commit_try (commit_try),
      .win_open   (win_open),
      .commit     (commit)
   );

   vbc_retire_hold u_hold (
      .clk    (clk),
      .rst_n  (rst_n),
      .commit (commit),
      .retire (retire),
      .hold   (hold)
   );

   vbc_boot_table #(
      .ADDR_W    (ADDR_W),
      .SIZE_W    (SIZE_W),
      .MEM_WORDS (MEM_WORDS),
      .BOOT_MIN  (BOOT_MIN)
   ) u_table (
      .code  (boot_size),
      .start (boot_start)
   );

   vbc_region_mask u_mask (
      .sel        (sel_q),
      .lock_app   (lock_app),
      .lock_boot  (lock_boot),
      .pc_in_boot (pc_in_boot),
      .lock_block (lock_block)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_q <= 1'b0;
      end else if (commit) begin
         sel_q <= wr_data[SEL_BIT];
      end
   end

   for (genvar b = 0; b < GEN_W; b++) begin : g_gen_bit
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            gen_q[b] <= 1'b0;
         end else if (wr_en) begin
            gen_q[b] <= wr_data[GEN_LO + b];
         end
      end
   end

   assign view.gen = gen_q;
   assign view.sel = sel_q;
   assign view.ce  = win_open;

   assign rdata     = view;
   assign vec_base  = sel_q ? boot_start : '0;
   assign irq_block = win_open | hold | lock_block;
endmodule

// File: rtl/vector_base_ctrl_chk.sv
module vector_base_ctrl_chk #(
   parameter int ADDR_W = 16,
   parameter int WINDOW = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [7:0]        wr_data,
   input logic              lock_app,
   input logic              lock_boot,
   input logic              pc_in_boot,
   input logic [ADDR_W-1:0] vec_base,
   input logic              irq_block,
   input logic [7:0]        rdata
);
   logic [7:0] ce_run;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ce_run <= '0;
      end else if (wr_en && wr_data[0]) begin
         ce_run <= '0;
      end else if (rdata[0]) begin
         ce_run <= ce_run + 8'd1;
      end else begin
         ce_run <= '0;
      end
   end

   p_base_app_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !rdata[1] |-> (vec_base == '0));

   p_sel_guard_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en || wr_data[0] || !rdata[0]) |=> $stable(rdata[1]));

   p_arm_opens_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[0]) |=> rdata[0]);

   p_window_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rdata[0] |-> (ce_run < 8'(WINDOW)));

   p_commit_closes_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_data[0] && rdata[0]) |=> !rdata[0]);

   p_window_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rdata[0] |-> irq_block);

   p_commit_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_data[0] && rdata[0]) |=> irq_block);

   p_lock_app_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rdata[1] && lock_app && !pc_in_boot) |-> irq_block);

   p_lock_boot_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!rdata[1] && lock_boot && pc_in_boot) |-> irq_block);

   p_gen_bits_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(rdata[7:2]));
endmodule

bind vector_base_ctrl vector_base_ctrl_chk #(.ADDR_W(ADDR_W), .WINDOW(WINDOW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en      (wr_en),
   .wr_data    (wr_data),
   .lock_app   (lock_app),
   .lock_boot  (lock_boot),
   .pc_in_boot (pc_in_boot),
   .vec_base   (vec_base),
   .irq_block  (irq_block),
   .rdata      (rdata)
);

// File: tb/vector_base_ctrl_test.sv
`timescale 1ns/1ps
module vector_base_ctrl_test;
   localparam int MEM_WORDS = 32768;
   localparam int BOOT_MIN  = 512;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  wr_data = '0;
   logic        retire = 1'b0;
   logic [1:0]  boot_size = '0;
   logic        lock_app = 1'b0;
   logic        lock_boot = 1'b0;
   logic        pc_in_boot = 1'b0;
   logic [15:0] vec_base;
   logic        irq_block;
   logic [7:0]  rdata;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   vector_base_ctrl uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .retire(retire), .boot_size(boot_size), .lock_app(lock_app),
      .lock_boot(lock_boot), .pc_in_boot(pc_in_boot),
      .vec_base(vec_base), .irq_block(irq_block), .rdata(rdata)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] d);
      wr_en = 1'b1;
      wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      wr_data = '0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic retire_pulse();
      retire = 1'b1;
      @(negedge clk);
      retire = 1'b0;
   endtask

   function automatic int boot_start(input int code);
      return MEM_WORDS - (BOOT_MIN << (3 - code));
   endfunction

   task automatic set_sel(input bit s);
      wr(8'h01);
      wr({6'b0, s, 1'b0});
      retire_pulse();
   endtask

   initial begin
      idle(3);
      rst_n = 1'b1;
      // R2 reset state
      chk("R2 reset rdata", rdata, 0);
      chk("R1 reset vec_base", vec_base, 0);
      chk("R7 reset irq_block", irq_block, 0);

      // R3 write with closed window: select ignored, bits 7:2 load (R2)
      wr(8'hFE);
      chk("R3 closed write rdata", rdata, 8'hFC);
      chk("R1 base stays app", vec_base, 0);

      // R4/R3 arm with bit1 set: select unchanged, window opens
      wr(8'hFF);
      chk("R3 arm keeps sel", rdata, 8'hFD);
      chk("R6 block on arm", irq_block, 1);
      idle(3);
      chk("R4 ce on 4th cycle", rdata[0], 1);
      // R5 commit on last accepted cycle
      wr(8'h02);
      chk("R5 commit rdata", rdata, 8'h02);
      chk("R1 boot base code0", vec_base, boot_start(0));
      chk("R7 block after commit", irq_block, 1);
      idle(2);
      chk("R7 block holds without retire", irq_block, 1);
      retire_pulse();
      chk("R7 release after retire", irq_block, 0);

      // R4 expiry, late write ignored (R5)
      wr(8'h01);
      chk("R10 arm keeps gen bits", rdata, 8'h03);
      idle(4);
      chk("R4 ce expired", rdata, 8'h02);
      chk("R7 block ends with window", irq_block, 0);
      wr(8'h00);
      chk("R5 late write ignored", rdata[1], 1);
      chk("R5 late base unchanged", vec_base, boot_start(0));

      // R4 re-arm restarts count
      wr(8'h81);
      idle(3);
      wr(8'h81);
      idle(3);
      chk("R4 rearm still open", rdata[0], 1);
      chk("R10 gen bits kept", rdata[7:2], 8'h81 >> 2);
      idle(1);
      chk("R4 rearm closes", rdata[0], 0);

      // R7 retire coinciding with commit does not count
      wr(8'h01);
      retire = 1'b1;
      wr(8'h00);
      retire = 1'b0;
      chk("R5 commit to app", rdata[1], 0);
      chk("R7 coincident retire ignored", irq_block, 1);
      idle(1);
      chk("R7 still held", irq_block, 1);
      retire_pulse();
      chk("R7 released", irq_block, 0);

      // sweep: select, boot size, locks, region
      for (int s = 0; s < 2; s++) begin
         set_sel(s[0]);
         for (int bs = 0; bs < 4; bs++) begin
            for (int m = 0; m < 8; m++) begin
               boot_size  = bs[1:0];
               lock_app   = m[0];
               lock_boot  = m[1];
               pc_in_boot = m[2];
               #1;
               chk("R1 sweep vec_base", vec_base, (s == 1) ? boot_start(bs) : 0);
               if (s == 1)
                  chk("R8 sweep app lock", irq_block, (m[0] && !m[2]) ? 1 : 0);
               else
                  chk("R9 sweep boot lock", irq_block, (m[1] && m[2]) ? 1 : 0);
               @(negedge clk);
            end
         end
      end
      lock_app = 1'b0;
      lock_boot = 1'b0;
      pc_in_boot = 1'b0;

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule